// File: doc/BRIEF.md
# Serial Configuration Receiver for a Stereo Audio Converter

This block receives configuration from a host microcontroller over three wires: a phase-select line, a serial clock and a serial data line. It never sends data back. It runs on the chip's system clock and samples all three lines through a synchronizer. An addressing byte, sent while the phase-select line is low, names the device and picks a register group. Bytes sent while the line is high then carry the field values.

The register contents drive the converter's configuration outputs directly:
- the ratio of the system clock to the sample rate,
- the serial audio input format,
- the volume attenuation,
- the de-emphasis curve,
- the mute flag.

A host normally sends one addressing byte and then as many value bytes as it needs. The selection stays in force until the next addressing byte arrives.

Top module: `ctl3w_port`

## Requirements
- R1: After reset the outputs read clock ratio 2'b10 (256x), format 3'b000, attenuation 0, de-emphasis 2'b00 and mute 0. No group is selected, so value bytes have no effect until a matching addressing byte arrives.
- R2: An addressing byte (phase line low) whose bits 7:2 equal the device address 6'b000101 and whose bits 1:0 are 2'b00 selects the data group. The data group holds attenuation, de-emphasis and mute.
- R3: An addressing byte with the device address and bits 1:0 equal to 2'b10 selects the status group. A status byte with bits 7:6 = 2'b00 loads bits 5:4 into the clock ratio (00 = 512x, 01 = 384x, 10 = 256x) and bits 3:1 into the input format.
- R4: An addressing byte carrying any other device address deselects the port. Value bytes are then ignored until the device address is received again.
- R5: A selection persists over any number of following value bytes.
- R6: In the data group, a byte with bits 7:6 = 2'b00 loads bits 5:0 as the attenuation in dB (0 to 63).
- R7: In the data group, a byte with bits 7:6 = 2'b10 loads bits 4:3 as de-emphasis (00 off, 01 32 kHz, 10 44.1 kHz, 11 48 kHz) and bit 2 as mute. Bytes with bits 7:6 = 2'b01 or 2'b11 are ignored.
- R8: In a status byte, a clock-ratio code of 2'b11 leaves the ratio unchanged. Format codes 3'b101 to 3'b111 leave the format unchanged. Valid format codes are 000 I2S, 001/010/011 LSB-justified 16/18/20 bits, and 100 MSB-justified. Each of the two fields is checked on its own.
- R9: A register changes only after all 8 bits of a byte have been received. Any change of the phase line clears the bit count and discards a partial byte.
- R10: An addressing byte with the device address but bits 1:0 equal to 2'b01 or 2'b11 selects no group, and value bytes are ignored.
- R11: In the status group, a byte whose bits 7:6 are not 2'b00 is ignored.
- R12: Data is taken on each rising edge of the serial clock, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_mode_i | input | 1 | Phase select: 0 addressing, 1 value bytes |
| ctl_clk_i | input | 1 | Serial clock from host, idles high |
| ctl_dat_i | input | 1 | Serial data from host |
| clk_ratio_o | output | 2 | System clock to sample rate ratio code |
| fmt_o | output | 3 | Serial audio input format code |
| atten_o | output | 6 | Volume attenuation in dB |
| deemph_o | output | 2 | De-emphasis selection |
| mute_o | output | 1 | Mute enable |

## Verification
Some faults only show up once the next value byte arrives:
- a stale or wrong group selection writes the wrong register;
- a miscounted bit leaves a byte assembled from shifted or mixed bits.

In both cases the error appears on the outputs a few system clocks after that byte's last serial clock edge. The bench therefore follows every addressing byte, partial byte and phase toggle with a value byte whose effect is known, and reads all five outputs after it. Invalid codes are caught as an output that moves when it should have held its value.

// File: rtl/ctl3w_pkg.sv
// Shared types and constants of the three-wire configuration receiver.
package ctl3w_pkg;

    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS);

    // Register group chosen by the last addressing byte
    typedef enum logic [1:0] {
        GRP_NONE   = 2'd0,
        GRP_DATA   = 2'd1,
        GRP_STATUS = 2'd2
    } grp_t;

    localparam logic [1:0] TYPE_DATA   = 2'b00;
    localparam logic [1:0] TYPE_STATUS = 2'b10;

    localparam logic [1:0] PFX_VOLUME  = 2'b00;
    localparam logic [1:0] PFX_DEMUTE  = 2'b10;
    localparam logic [1:0] PFX_STATUS  = 2'b00;

    localparam logic [1:0] RATIO_RST   = 2'b10;
    localparam logic [2:0] FMT_RST     = 3'b000;
    localparam logic [2:0] FMT_MAX     = 3'b100;
    localparam logic [1:0] RATIO_BAD   = 2'b11;

    // True when a clock-ratio code names a supported ratio
    function automatic logic ratio_ok(input logic [1:0] code);
        return code != RATIO_BAD;
    endfunction

    // True when an input-format code names a supported format
    function automatic logic fmt_ok(input logic [2:0] code);
        return code <= FMT_MAX;
    endfunction

endpackage

// File: rtl/ctl3w_sync.sv
// Multi-stage synchronizer for a bus of independent asynchronous lines.
// Assumes each line is held for several system clocks by the sender.
// Reset value per line is a parameter so idle-high lines do not create
// a false edge when reset is released.
module ctl3w_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    // Shift every line through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/ctl3w_shifter.sv
// Byte assembler: detects rising serial clock edges, shifts data in
// MSB first, and emits a one-cycle strobe with the completed byte and
// the phase it was received in. A phase change clears the bit count.
// Assumes synchronized inputs and a serial clock that idles high.
module ctl3w_shifter
    import ctl3w_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_s,
    input  logic                 sclk_s,
    input  logic                 sdat_s,
    output logic                 byte_stb_o,
    output logic [BYTE_BITS-1:0] byte_dat_o,
    output logic                 byte_addr_o
);

    logic                 sclk_q;
    logic                 mode_q;
    logic [CNT_W-1:0]     cnt;
    logic [BYTE_BITS-1:0] shreg;
    logic                 rise;
    logic [BYTE_BITS-1:0] next_sh;

    // Rising edge of the serial clock and the shift value it would load
    always_comb begin
        rise    = sclk_s && !sclk_q;
        next_sh = {shreg[BYTE_BITS-2:0], sdat_s};
    end

    // Edge tracking, bit counting and byte completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q      <= 1'b1;
            mode_q      <= 1'b0;
            cnt         <= '0;
            shreg       <= '0;
            byte_stb_o  <= 1'b0;
            byte_dat_o  <= '0;
            byte_addr_o <= 1'b0;
        end else begin
            sclk_q     <= sclk_s;
            mode_q     <= mode_s;
            byte_stb_o <= 1'b0;
            if (mode_s != mode_q) begin
                cnt <= '0;
            end else if (rise) begin
                shreg <= next_sh;
                if (cnt == CNT_W'(BYTE_BITS - 1)) begin
                    cnt         <= '0;
                    byte_stb_o  <= 1'b1;
                    byte_dat_o  <= next_sh;
                    byte_addr_o <= !mode_s;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ctl3w_addr.sv
// Address decoder: on every completed addressing byte, compares the
// device address and latches which register group is selected. The
// selection holds until the next addressing byte.
module ctl3w_addr
    import ctl3w_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR = 6'b000101
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 byte_stb_i,
    input  logic                 byte_addr_i,
    input  logic [BYTE_BITS-1:0] byte_dat_i,
    output grp_t                 grp_o
);

    grp_t grp_nx;

    // Group named by an addressing byte
    always_comb begin
        grp_nx = GRP_NONE;
        if (byte_dat_i[7:2] == DEV_ADDR) begin
            case (byte_dat_i[1:0])
                TYPE_DATA:   grp_nx = GRP_DATA;
                TYPE_STATUS: grp_nx = GRP_STATUS;
                default:     grp_nx = GRP_NONE;
            endcase
        end
    end

    // Latch the selection on addressing bytes only
    always_ff @(posedge clk) begin
        if (!rst_n)                          grp_o <= GRP_NONE;
        else if (byte_stb_i && byte_addr_i)  grp_o <= grp_nx;
    end

endmodule

// File: rtl/ctl3w_cfg.sv
// Configuration register file: applies completed value bytes to the
// selected group, checks codes, and holds the outputs between writes.
module ctl3w_cfg
    import ctl3w_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 byte_stb_i,
    input  logic                 byte_addr_i,
    input  logic [BYTE_BITS-1:0] byte_dat_i,
    input  grp_t                 grp_i,
    output logic [1:0]           ratio_o,
    output logic [2:0]           fmt_o,
    output logic [5:0]           atten_o,
    output logic [1:0]           deemph_o,
    output logic                 mute_o
);

    logic       wr;
    logic [1:0] pfx;

    // Value byte write strobe and its register prefix
    always_comb begin
        wr  = byte_stb_i && !byte_addr_i;
        pfx = byte_dat_i[7:6];
    end

    // Status group: clock ratio and input format, each field validated
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_o <= RATIO_RST;
            fmt_o   <= FMT_RST;
        end else if (wr && grp_i == GRP_STATUS && pfx == PFX_STATUS) begin
            if (ratio_ok(byte_dat_i[5:4])) ratio_o <= byte_dat_i[5:4];
            if (fmt_ok(byte_dat_i[3:1]))   fmt_o   <= byte_dat_i[3:1];
        end
    end

    // Data group: volume, or de-emphasis with mute
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            atten_o  <= '0;
            deemph_o <= '0;
            mute_o   <= 1'b0;
        end else if (wr && grp_i == GRP_DATA) begin
            if (pfx == PFX_VOLUME) begin
                atten_o <= byte_dat_i[5:0];
            end else if (pfx == PFX_DEMUTE) begin
                deemph_o <= byte_dat_i[4:3];
                mute_o   <= byte_dat_i[2];
            end
        end
    end

endmodule

// File: rtl/ctl3w_port.sv
// Top of the three-wire configuration receiver. Synchronizes the host
// lines, assembles bytes, decodes the addressing phase and updates the
// configuration registers. Receive only.
module ctl3w_port
    import ctl3w_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR    = 6'b000101,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_mode_i,
    input  logic       ctl_clk_i,
    input  logic       ctl_dat_i,
    output logic [1:0] clk_ratio_o,
    output logic [2:0] fmt_o,
    output logic [5:0] atten_o,
    output logic [1:0] deemph_o,
    output logic       mute_o
);

    logic [2:0]           lines_s;
    logic                 byte_stb;
    logic [BYTE_BITS-1:0] byte_dat;
    logic                 byte_addr;
    grp_t                 grp;

    ctl3w_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ctl_mode_i, ctl_clk_i, ctl_dat_i}),
        .q_o   (lines_s)
    );

    ctl3w_shifter u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_s      (lines_s[2]),
        .sclk_s      (lines_s[1]),
        .sdat_s      (lines_s[0]),
        .byte_stb_o  (byte_stb),
        .byte_dat_o  (byte_dat),
        .byte_addr_o (byte_addr)
    );

    ctl3w_addr #(.DEV_ADDR(DEV_ADDR)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_stb_i  (byte_stb),
        .byte_addr_i (byte_addr),
        .byte_dat_i  (byte_dat),
        .grp_o       (grp)
    );

    ctl3w_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_stb_i  (byte_stb),
        .byte_addr_i (byte_addr),
        .byte_dat_i  (byte_dat),
        .grp_i       (grp),
        .ratio_o     (clk_ratio_o),
        .fmt_o       (fmt_o),
        .atten_o     (atten_o),
        .deemph_o    (deemph_o),
        .mute_o      (mute_o)
    );

endmodule

// File: rtl/ctl3w_port_chk.sv
// Assertion checker for ctl3w_port, attached by bind below.
module ctl3w_port_chk
    import ctl3w_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR = 6'b000101
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 byte_stb,
    input logic                 byte_addr,
    input logic [BYTE_BITS-1:0] byte_dat,
    input grp_t                 grp,
    input logic [1:0]           clk_ratio_o,
    input logic [2:0]           fmt_o,
    input logic [5:0]           atten_o,
    input logic [1:0]           deemph_o,
    input logic                 mute_o
);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_stb |=> $stable({clk_ratio_o, fmt_o, atten_o, deemph_o, mute_o}));

    assert_status_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !byte_addr && grp != GRP_STATUS) |=> $stable({clk_ratio_o, fmt_o}));

    assert_data_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !byte_addr && grp != GRP_DATA) |=> $stable({atten_o, deemph_o, mute_o}));

    assert_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && byte_addr && byte_dat[7:2] != DEV_ADDR) |=> grp == GRP_NONE);

    assert_sel_persist_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_stb && byte_addr) |=> $stable(grp));

    assert_codes_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_ratio_o != 2'b11) && (fmt_o <= 3'b100));

endmodule

bind ctl3w_port ctl3w_port_chk #(.DEV_ADDR(DEV_ADDR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_stb    (byte_stb),
    .byte_addr   (byte_addr),
    .byte_dat    (byte_dat),
    .grp         (grp),
    .clk_ratio_o (clk_ratio_o),
    .fmt_o       (fmt_o),
    .atten_o     (atten_o),
    .deemph_o    (deemph_o),
    .mute_o      (mute_o)
);

// File: tb/test_ctl3w_port.sv
// Self-checking bench: sweeps every value code in both groups, every
// transfer type, foreign addresses and partial bytes.
module test_ctl3w_port;

    localparam logic [5:0] DEV = 6'b000101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_mode = 1'b0;
    logic       ctl_clk = 1'b1;
    logic       ctl_dat = 1'b0;
    logic [1:0] clk_ratio;
    logic [2:0] fmt;
    logic [5:0] atten;
    logic [1:0] deemph;
    logic       mute;

    int checks = 0;
    int errors = 0;

    // Expected state from the requirements
    int         m_grp = 0;           // 0 none, 1 data, 2 status
    logic [1:0] e_rat = 2'b10;
    logic [2:0] e_fmt = 3'b000;
    logic [5:0] e_att = 6'd0;
    logic [1:0] e_de  = 2'b00;
    logic       e_mu  = 1'b0;

    always #2 clk = ~clk;

    ctl3w_port i_ctl3w_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_mode_i  (ctl_mode),
        .ctl_clk_i   (ctl_clk),
        .ctl_dat_i   (ctl_dat),
        .clk_ratio_o (clk_ratio),
        .fmt_o       (fmt),
        .atten_o     (atten),
        .deemph_o    (deemph),
        .mute_o      (mute)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " ratio"},  clk_ratio, e_rat);
        chk({tag, " format"}, fmt,       e_fmt);
        chk({tag, " atten"},  atten,     e_att);
        chk({tag, " deemph"}, deemph,    e_de);
        chk({tag, " mute"},   mute,      e_mu);
    endtask

    // Drive n MSBs of a byte in the given phase
    task automatic send_bits(input logic mode, input logic [7:0] b, input int n);
        if (ctl_mode != mode) begin
            ctl_mode = mode;
            wait_cyc(6);
        end
        for (int i = 7; i > 7 - n; i--) begin
            ctl_clk = 1'b0;
            ctl_dat = b[i];
            wait_cyc(4);
            ctl_clk = 1'b1;
            wait_cyc(4);
        end
    endtask

    // Full byte, model update, settle
    task automatic send_byte(input logic is_addr, input logic [7:0] b);
        send_bits(!is_addr, b, 8);
        if (is_addr) begin
            if (b[7:2] == DEV) m_grp = (b[1:0] == 2'b00) ? 1 : (b[1:0] == 2'b10) ? 2 : 0;
            else               m_grp = 0;
        end else if (m_grp == 1) begin
            if (b[7:6] == 2'b00) e_att = b[5:0];
            else if (b[7:6] == 2'b10) begin e_de = b[4:3]; e_mu = b[2]; end
        end else if (m_grp == 2 && b[7:6] == 2'b00) begin
            if (b[5:4] != 2'b11) e_rat = b[5:4];
            if (b[3:1] <= 3'b100) e_fmt = b[3:1];
        end
        wait_cyc(8);
    endtask

    // Watchdog
    initial begin
        wait_cyc(150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(6);
        chk_all("R1 reset");

        // R1: deselected after reset, value byte ignored
        send_byte(1'b0, 8'h2A);
        chk_all("R1 deselected");

        // R10 / R2 / R3: every transfer type with one probe byte
        for (int t = 0; t < 4; t++) begin
            send_byte(1'b1, {DEV, 2'(t)});
            send_byte(1'b0, 8'h16 + 8'(t));
            chk_all(t == 0 ? "R2 type" : (t == 2 ? "R3 type" : "R10 type"));
        end

        // R6 / R12 / R5: full volume sweep under one selection
        send_byte(1'b1, {DEV, 2'b00});
        for (int v = 0; v < 64; v++) begin
            send_byte(1'b0, {2'b00, 6'(v)});
            chk("R6 R12 atten sweep", atten, v);
        end
        chk_all("R5 persist");

        // R7: de-emphasis and mute, then ignored prefixes
        for (int d = 0; d < 8; d++) begin
            send_byte(1'b0, {2'b10, 1'b0, 3'(d), 2'b00});
            chk_all("R7 demute");
        end
        send_byte(1'b0, 8'h7F);
        chk_all("R7 prefix 01 ignored");
        send_byte(1'b0, 8'hC4);
        chk_all("R7 prefix 11 ignored");

        // R3 / R8: status sweep of ratio and format codes
        send_byte(1'b1, {DEV, 2'b10});
        for (int sc = 0; sc < 4; sc++) begin
            for (int f = 0; f < 8; f++) begin
                send_byte(1'b0, {2'b00, 2'(sc), 3'(f), 1'b0});
                chk_all("R3 R8 status sweep");
            end
        end

        // R11: status bytes with other prefixes ignored
        for (int p = 1; p < 4; p++) begin
            send_byte(1'b0, {2'(p), 2'b01, 3'b010, 1'b0});
            chk_all("R11 prefix ignored");
        end

        // R4: foreign addresses (every single-bit flip) deselect
        for (int k = 0; k < 6; k++) begin
            send_byte(1'b1, {DEV, 2'b00});
            send_byte(1'b0, 8'h01 + 8'(k));
            send_byte(1'b1, {DEV ^ (6'b1 << k), 2'b00});
            send_byte(1'b0, 8'h30 + 8'(k));
            chk_all("R4 foreign address");
        end
        send_byte(1'b1, {DEV, 2'b00});
        send_byte(1'b0, 8'h2D);
        chk_all("R4 reselect");

        // R9: partial value byte discarded on phase change
        send_bits(1'b1, 8'h3C, 5);
        wait_cyc(8);
        chk_all("R9 partial no update");
        ctl_mode = 1'b0;
        wait_cyc(6);
        send_byte(1'b0, 8'h11);
        chk_all("R9 after toggle");

        // R9: partial addressing byte discarded, selection kept
        send_bits(1'b0, 8'hFF, 6);
        send_byte(1'b0, 8'h07);
        chk_all("R9 partial address");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule